// File: doc/BRIEF.md
# Submission Ring Producer with Slot Allocation

This block is the host-side producer for one command submission ring. A client hands it commands over a valid/ready handshake. For each accepted command the block claims the lowest idle request slot and stamps the slot's identifier (slot index plus one) into the entry. It writes the entry to the ring memory at the current tail, and once the memory acknowledges the write it advances the tail. Entries that are written but not yet announced are counted as pending.

Pending entries are announced to the consumer by a write of the tail value to a doorbell register, and that write turns them into in-flight commands. A plug input holds doorbell writes back so that several commands can be announced with a single write. When plug drops, the held doorbell write goes out at once. A completion path, outside this block, reports finished commands by identifier on a release input, which frees the slot. Admission stops while in-flight plus pending exceeds the ring depth minus two, so one ring entry is always left empty.

Top module: `sq_producer`

## Requirements
- R1: After synchronous reset, cmd_ready is high, mem_wr_en and db_wr_en are low, and no slot is busy.
- R2: An accepted command is written once at mem_wr_addr equal to the current tail. Bits 31:16 of mem_wr_data carry the 16-bit identifier, and every other bit equals cmd_data.
- R3: The identifier of slot i is i+1, and each accepted command takes the lowest-numbered idle slot.
- R4: The tail advances by one, modulo DEPTH, in the cycle the entry write is acknowledged. Each doorbell write carries the tail value after all announced entries, zero-extended to 32 bits.
- R5: A doorbell write is issued only while plug is low and at least one entry is pending. It goes to word address QP_INDEX*2*(1<<STRIDE) and moves the whole pending count into the in-flight count.
- R6: While plug is high no doorbell write occurs. In the cycle after plug falls with N entries pending, exactly one doorbell write announces all N.
- R7: A doorbell write never overlaps an unacknowledged entry write. Only one entry write is outstanding at a time, and cmd_ready is low while it is.
- R8: cmd_ready is low whenever in-flight plus pending exceeds DEPTH-2, so at most DEPTH-1 commands are outstanding.
- R9: A release whose identifier names a busy, in-flight slot clears that slot and lowers the in-flight count by one. A freed slot is reused by the next command.
- R10: A release with identifier 0, with an identifier above DEPTH, or naming an idle slot has no effect.
- R11: Bits 15:8 of every doorbell data word are zero (DEPTH is at most 256).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be accepted this cycle |
| cmd_data | input | ENTRY_W | Command entry body (identifier field overwritten) |
| plug | input | 1 | Hold doorbell writes while high |
| rel_valid | input | 1 | Completion release strobe |
| rel_id | input | ID_W | Identifier of the completed command |
| mem_wr_en | output | 1 | Entry write request, held until acknowledged |
| mem_wr_addr | output | IDX_W | Ring entry index being written |
| mem_wr_data | output | ENTRY_W | Entry contents |
| mem_wr_ack | input | 1 | Entry write acknowledge |
| db_wr_en | output | 1 | One-cycle doorbell register write |
| db_wr_addr | output | DB_AW | Doorbell word address |
| db_wr_data | output | 32 | Tail value written to the doorbell |

## Verification
The bench builds the block with DEPTH=8, ENTRY_W=64, QP_INDEX=2 and STRIDE=1, which puts the doorbell at word 8. With an 8-entry ring, the admission limit of seven outstanding commands and the tail wrap both come up within a few dozen commands. The same depth lets out-of-range release identifiers such as 9 fit in the 4-bit identifier port. An adjustable acknowledge delay stretches the entry write, so the bench can watch that no doorbell write comes out before the acknowledge.

// File: rtl/sqp_pkg.sv
package sqp_pkg;
  typedef enum logic [0:0] {
    WR_IDLE = 1'b0,
    WR_WAIT = 1'b1
  } wr_state_e;

  localparam int unsigned ID_LSB = 16;
  localparam int unsigned ID_BITS = 16;
endpackage

// File: rtl/sqp_slot_pool.sv
module sqp_slot_pool #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned IDX_W = $clog2(DEPTH),
  parameter int unsigned ID_W  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc_en,
  output logic [IDX_W-1:0] alloc_idx,
  output logic             any_free,
  input  logic             rel_valid,
  input  logic [ID_W-1:0]  rel_id,
  input  logic             rel_gate,
  output logic             rel_ok
);
  logic [DEPTH-1:0] busy;
  logic [IDX_W-1:0] rel_idx;
  logic             id_in_range;

  // lowest idle slot wins: scan from the top so the last hit is the lowest
  always_comb begin
    alloc_idx = '0;
    any_free  = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        alloc_idx = IDX_W'(i);
        any_free  = 1'b1;
      end
    end
  end

  assign rel_idx     = IDX_W'(rel_id - ID_W'(1));
  assign id_in_range = (rel_id != '0) && (rel_id <= ID_W'(DEPTH));
  assign rel_ok      = rel_valid && id_in_range && busy[rel_idx] && rel_gate;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= '0;
    end else begin
      if (alloc_en) busy[alloc_idx] <= 1'b1;
      if (rel_ok)   busy[rel_idx]   <= 1'b0;
    end
  end

  // R9
  release_clears_chk: assert property (@(posedge clk) disable iff (rst)
    rel_ok |=> (busy[$past(rel_idx)] == 1'b0));

  // R3
  alloc_idle_chk: assert property (@(posedge clk) disable iff (rst)
    alloc_en |-> (any_free && !busy[alloc_idx]));
endmodule

// File: rtl/sqp_entry_writer.sv
module sqp_entry_writer
  import sqp_pkg::*;
#(
  parameter int unsigned DEPTH   = 128,
  parameter int unsigned ENTRY_W = 512,
  parameter int unsigned IDX_W   = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [ENTRY_W-1:0] start_data,
  input  logic [IDX_W-1:0]   start_slot,
  output logic               mem_wr_en,
  output logic [IDX_W-1:0]   mem_wr_addr,
  output logic [ENTRY_W-1:0] mem_wr_data,
  input  logic               mem_wr_ack,
  output logic               busy,
  output logic               done,
  output logic [IDX_W-1:0]   tail
);
  wr_state_e          state;
  logic [ENTRY_W-1:0] entry_word;
  logic [IDX_W-1:0]   tail_next;

  always_comb begin
    entry_word = start_data;
    entry_word[ID_LSB +: ID_BITS] = ID_BITS'(start_slot) + ID_BITS'(1);
  end

  assign tail_next = (tail == IDX_W'(DEPTH - 1)) ? '0 : tail + IDX_W'(1);
  assign busy      = (state == WR_WAIT);
  assign done      = busy && mem_wr_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= WR_IDLE;
      mem_wr_en   <= 1'b0;
      mem_wr_addr <= '0;
      mem_wr_data <= '0;
      tail        <= '0;
    end else begin
      case (state)
        WR_IDLE: begin
          if (start) begin
            state       <= WR_WAIT;
            mem_wr_en   <= 1'b1;
            mem_wr_addr <= tail;
            mem_wr_data <= entry_word;
          end
        end
        WR_WAIT: begin
          if (mem_wr_ack) begin
            state     <= WR_IDLE;
            mem_wr_en <= 1'b0;
            tail      <= tail_next;
          end
        end
        default: state <= WR_IDLE;
      endcase
    end
  end

  // R2
  id_range_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> ((mem_wr_data[ID_LSB +: ID_BITS] != '0) &&
                   (mem_wr_data[ID_LSB +: ID_BITS] <= ID_BITS'(DEPTH))));

  // R7
  write_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_en && !mem_wr_ack) |=> (mem_wr_en && $stable(mem_wr_data) && $stable(mem_wr_addr)));

  // R4
  tail_step_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_en && mem_wr_ack) |=> (tail != $past(tail)));
endmodule

// File: rtl/sqp_doorbell.sv
module sqp_doorbell #(
  parameter int unsigned DEPTH   = 128,
  parameter int unsigned IDX_W   = $clog2(DEPTH),
  parameter int unsigned CNT_W   = $clog2(DEPTH + 1),
  parameter int unsigned DB_AW   = 16,
  parameter int unsigned DB_WORD = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             plug,
  input  logic             entry_done,
  input  logic             writer_busy,
  input  logic [IDX_W-1:0] tail,
  input  logic             rel_ok,
  output logic             fire_due,
  output logic [CNT_W-1:0] pending,
  output logic [CNT_W-1:0] inflight,
  output logic             db_wr_en,
  output logic [DB_AW-1:0] db_wr_addr,
  output logic [31:0]      db_wr_data
);
  logic [CNT_W-1:0] pending_n;
  logic [CNT_W-1:0] inflight_n;

  // a doorbell goes out only with no entry write in progress
  assign fire_due = !plug && (pending != '0) && !writer_busy;

  always_comb begin
    pending_n  = fire_due ? '0 : pending;
    if (entry_done) pending_n = pending_n + CNT_W'(1);
    inflight_n = inflight;
    if (fire_due) inflight_n = inflight_n + pending;
    if (rel_ok)   inflight_n = inflight_n - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pending    <= '0;
      inflight   <= '0;
      db_wr_en   <= 1'b0;
      db_wr_addr <= '0;
      db_wr_data <= '0;
    end else begin
      pending  <= pending_n;
      inflight <= inflight_n;
      db_wr_en <= fire_due;
      if (fire_due) begin
        db_wr_addr <= DB_AW'(DB_WORD);
        db_wr_data <= 32'(tail);
      end
    end
  end

  // R6
  plug_hold_chk: assert property (@(posedge clk) disable iff (rst)
    plug |=> !db_wr_en);

  // R5
  pending_drain_chk: assert property (@(posedge clk) disable iff (rst)
    db_wr_en |-> (pending == '0));

  // R11
  tail_range_chk: assert property (@(posedge clk) disable iff (rst)
    db_wr_en |-> (db_wr_data[15:8] == 8'h00));
endmodule

// File: rtl/sq_producer.sv
module sq_producer #(
  parameter int unsigned DEPTH    = 128,
  parameter int unsigned ENTRY_W  = 512,
  parameter int unsigned QP_INDEX = 1,
  parameter int unsigned STRIDE   = 0,
  parameter int unsigned DB_AW    = 16,
  localparam int unsigned IDX_W   = $clog2(DEPTH),
  localparam int unsigned ID_W    = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [ENTRY_W-1:0] cmd_data,
  input  logic               plug,
  input  logic               rel_valid,
  input  logic [ID_W-1:0]    rel_id,
  output logic               mem_wr_en,
  output logic [IDX_W-1:0]   mem_wr_addr,
  output logic [ENTRY_W-1:0] mem_wr_data,
  input  logic               mem_wr_ack,
  output logic               db_wr_en,
  output logic [DB_AW-1:0]   db_wr_addr,
  output logic [31:0]        db_wr_data
);
  localparam int unsigned CNT_W   = $clog2(DEPTH + 1);
  localparam int unsigned SCALE   = 1 << STRIDE;
  localparam int unsigned DB_WORD = QP_INDEX * 2 * SCALE;

  logic             accept;
  logic [IDX_W-1:0] alloc_idx;
  logic             any_free;
  logic             rel_ok;
  logic             writer_busy;
  logic             entry_done;
  logic [IDX_W-1:0] tail;
  logic             fire_due;
  logic [CNT_W-1:0] pending;
  logic [CNT_W-1:0] inflight;
  logic [CNT_W:0]   occupancy;

  assign occupancy = {1'b0, inflight} + {1'b0, pending};
  assign cmd_ready = !writer_busy && !fire_due && any_free &&
                     (occupancy <= (CNT_W + 1)'(DEPTH - 2));
  assign accept    = cmd_valid && cmd_ready;

  sqp_slot_pool #(
    .DEPTH(DEPTH), .IDX_W(IDX_W), .ID_W(ID_W)
  ) u_pool (
    .clk       (clk),
    .rst       (rst),
    .alloc_en  (accept),
    .alloc_idx (alloc_idx),
    .any_free  (any_free),
    .rel_valid (rel_valid),
    .rel_id    (rel_id),
    .rel_gate  (inflight != '0),
    .rel_ok    (rel_ok)
  );

  sqp_entry_writer #(
    .DEPTH(DEPTH), .ENTRY_W(ENTRY_W), .IDX_W(IDX_W)
  ) u_writer (
    .clk         (clk),
    .rst         (rst),
    .start       (accept),
    .start_data  (cmd_data),
    .start_slot  (alloc_idx),
    .mem_wr_en   (mem_wr_en),
    .mem_wr_addr (mem_wr_addr),
    .mem_wr_data (mem_wr_data),
    .mem_wr_ack  (mem_wr_ack),
    .busy        (writer_busy),
    .done        (entry_done),
    .tail        (tail)
  );

  sqp_doorbell #(
    .DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W), .DB_AW(DB_AW), .DB_WORD(DB_WORD)
  ) u_db (
    .clk         (clk),
    .rst         (rst),
    .plug        (plug),
    .entry_done  (entry_done),
    .writer_busy (writer_busy),
    .tail        (tail),
    .rel_ok      (rel_ok),
    .fire_due    (fire_due),
    .pending     (pending),
    .inflight    (inflight),
    .db_wr_en    (db_wr_en),
    .db_wr_addr  (db_wr_addr),
    .db_wr_data  (db_wr_data)
  );

  // R8
  ring_room_chk: assert property (@(posedge clk) disable iff (rst)
    occupancy <= (CNT_W + 1)'(DEPTH - 1));

  // R7
  single_write_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> !cmd_ready);

  // R7
  order_chk: assert property (@(posedge clk) disable iff (rst)
    db_wr_en |-> !mem_wr_en);

  // R10
  bad_release_chk: assert property (@(posedge clk) disable iff (rst)
    (rel_valid && (rel_id == '0)) |-> !rel_ok);
endmodule

// File: tb/sq_producer_test.sv
module sq_producer_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH   = 8;
  localparam int ENTRY_W = 64;
  localparam int IDX_W   = $clog2(DEPTH);
  localparam int ID_W    = $clog2(DEPTH + 1);
  localparam int DB_AW   = 8;
  localparam int EXP_DB  = 2 * 2 * 2; // QP_INDEX=2, STRIDE=1

  logic               clk = 0;
  logic               rst = 1;
  logic               cmd_valid = 0;
  logic               cmd_ready;
  logic [ENTRY_W-1:0] cmd_data = '0;
  logic               plug = 0;
  logic               rel_valid = 0;
  logic [ID_W-1:0]    rel_id = '0;
  logic               mem_wr_en;
  logic [IDX_W-1:0]   mem_wr_addr;
  logic [ENTRY_W-1:0] mem_wr_data;
  logic               mem_wr_ack = 0;
  logic               db_wr_en;
  logic [DB_AW-1:0]   db_wr_addr;
  logic [31:0]        db_wr_data;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  int db_count, mem_count, ack_delay, wait_cnt, order_bad;
  int last_db_data, last_db_addr, last_mem_addr;
  logic [ENTRY_W-1:0] last_mem_data;

  sq_producer #(
    .DEPTH(DEPTH), .ENTRY_W(ENTRY_W), .QP_INDEX(2), .STRIDE(1), .DB_AW(DB_AW)
  ) uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .plug(plug), .rel_valid(rel_valid), .rel_id(rel_id),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .mem_wr_ack(mem_wr_ack), .db_wr_en(db_wr_en), .db_wr_addr(db_wr_addr),
    .db_wr_data(db_wr_data)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  // memory and doorbell side model, all on the falling edge
  always @(negedge clk) begin
    if (db_wr_en) begin
      db_count++;
      last_db_data = db_wr_data;
      last_db_addr = int'(db_wr_addr);
      if (mem_wr_en) order_bad++;
    end
    if (mem_wr_ack) begin
      mem_wr_ack = 0;
    end else if (mem_wr_en) begin
      if (wait_cnt < ack_delay) begin
        wait_cnt++;
      end else begin
        wait_cnt = 0;
        mem_count++;
        last_mem_addr = int'(mem_wr_addr);
        last_mem_data = mem_wr_data;
        mem_wr_ack = 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; cmd_valid = 0; plug = 0; rel_valid = 0; ack_delay = 0;
    db_count = 0; mem_count = 0; wait_cnt = 0; order_bad = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
  endtask

  task automatic send(input logic [ENTRY_W-1:0] d);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1;
    cmd_data  = d;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic send_wait(input logic [ENTRY_W-1:0] d);
    send(d);
    repeat (4) @(negedge clk);
  endtask

  task automatic release_id(input int id);
    rel_valid = 1;
    rel_id    = ID_W'(id);
    @(negedge clk);
    rel_valid = 0;
    @(negedge clk);
  endtask

  function automatic int id_of(input logic [ENTRY_W-1:0] d);
    return int'(d[31:16]);
  endfunction

  task automatic t_reset();
    do_reset();
    chk(cmd_ready == 1, "R1 ready after reset", cmd_ready, 1);
    chk(mem_wr_en == 0 && db_wr_en == 0, "R1 no writes after reset", mem_wr_en + db_wr_en, 0);
  endtask

  task automatic t_single();
    logic [ENTRY_W-1:0] d;
    do_reset();
    d = 64'hA5A5_1234_FFFF_0F0F;
    send_wait(d);
    chk(mem_count == 1, "R2 one entry write", mem_count, 1);
    chk(last_mem_addr == 0, "R2 entry at tail 0", last_mem_addr, 0);
    chk(id_of(last_mem_data) == 1, "R3 first id is 1", id_of(last_mem_data), 1);
    chk({last_mem_data[63:32], last_mem_data[15:0]} == {d[63:32], d[15:0]},
        "R2 body bits kept", last_mem_data[15:0], d[15:0]);
    chk(db_count == 1, "R5 one doorbell", db_count, 1);
    chk(last_db_addr == EXP_DB, "R5 doorbell address", last_db_addr, EXP_DB);
    chk(last_db_data == 1, "R4 doorbell tail 1", last_db_data, 1);
  endtask

  task automatic t_lowest();
    do_reset();
    for (int k = 1; k <= 4; k++) begin
      send_wait(64'(k) << 40);
      chk(id_of(last_mem_data) == k, "R3 ascending ids", id_of(last_mem_data), k);
    end
    release_id(2);
    send_wait('0);
    chk(id_of(last_mem_data) == 2, "R9 freed slot reused", id_of(last_mem_data), 2);
    chk(last_mem_addr == 4, "R4 tail keeps advancing", last_mem_addr, 4);
    send_wait('0);
    chk(id_of(last_mem_data) == 5, "R3 lowest idle next", id_of(last_mem_data), 5);
  endtask

  task automatic t_plug();
    do_reset();
    plug = 1;
    send_wait(64'h11);
    send_wait(64'h22);
    chk(mem_count == 2, "R6 entries written under plug", mem_count, 2);
    chk(db_count == 0, "R6 no doorbell under plug", db_count, 0);
    plug = 0;
    repeat (3) @(negedge clk);
    chk(db_count == 1, "R6 one combined doorbell", db_count, 1);
    chk(last_db_data == 2, "R6 combined tail", last_db_data, 2);
  endtask

  task automatic t_ack_order();
    do_reset();
    ack_delay = 6;
    send(64'h33);
    repeat (4) @(negedge clk);
    chk(mem_wr_en == 1, "R7 write held until ack", mem_wr_en, 1);
    chk(cmd_ready == 0, "R7 ready low during write", cmd_ready, 0);
    chk(db_count == 0, "R7 no doorbell before ack", db_count, 0);
    repeat (10) @(negedge clk);
    chk(db_count == 1, "R7 doorbell after ack", db_count, 1);
    chk(order_bad == 0, "R7 no overlap", order_bad, 0);
    ack_delay = 0;
  endtask

  task automatic t_full();
    do_reset();
    for (int k = 1; k <= DEPTH - 1; k++) begin
      if (k == DEPTH - 1)
        chk(cmd_ready == 1, "R8 ready at limit edge", cmd_ready, 1);
      send_wait('0);
    end
    chk(cmd_ready == 0, "R8 ready low when full", cmd_ready, 0);
    chk(mem_count == DEPTH - 1, "R8 outstanding count", mem_count, DEPTH - 1);
    release_id(0);
    chk(cmd_ready == 0, "R10 id 0 ignored", cmd_ready, 0);
    release_id(DEPTH + 1);
    chk(cmd_ready == 0, "R10 id above depth ignored", cmd_ready, 0);
    release_id(DEPTH);
    chk(cmd_ready == 0, "R10 idle slot ignored", cmd_ready, 0);
    release_id(5);
    chk(cmd_ready == 1, "R9 release reopens", cmd_ready, 1);
    send_wait('0);
    chk(id_of(last_mem_data) == 5, "R9 released id reused", id_of(last_mem_data), 5);
    chk(cmd_ready == 0, "R8 full again", cmd_ready, 0);
  endtask

  task automatic t_wrap();
    do_reset();
    for (int k = 1; k <= 10; k++) begin
      send_wait('0);
      release_id(1);
    end
    chk(last_mem_addr == 1, "R4 tail wrapped address", last_mem_addr, 1);
    chk(last_db_data == 2, "R4 doorbell wraps", last_db_data, 2);
    chk(last_db_data[15:8] == 0, "R11 tail high bits clear", last_db_data[15:8], 0);
    chk(db_count == 10, "R5 doorbell per command", db_count, 10);
  endtask

  initial begin
    t_reset();
    t_single();
    t_lowest();
    t_plug();
    t_ack_order();
    t_full();
    t_wrap();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule